// File: doc/BRIEF.md
# Program Run-Control Pulse Generator

This block issues the load pulses that start, stop and park a small microprogram sequencer. Two asynchronous requests, start and stop, are brought into the clock domain and reduced to single rising-edge events. A start event becomes a two-clock "load the first address" pulse. A stop event becomes a two-clock "load the terminal address" pulse. The same terminal load is also raised once after power-up, when an internal settle timer finishes, and whenever the program counter is found beyond the terminal address.

The sequencer feeds back its program counter and the constant terminal address. The block compares the two and reports on a registered status bit whether the program is parked at the terminal address or running. The block holds no program storage, does no decoding and contains no counter datapath.

Top module: `run_ctl`

## Requirements
- R1: The first clock edge that samples `start_req` high is edge 1. The start edge is then seen at edge 3. `load_begin` is high after edges 3 and 4 and low after edge 5. `begin_first` is high only after edge 3. This holds for any request width of at least one clock.
- R2: A start request held high produces only one `load_begin` pair. Another pair needs `start_req` to go low and then rise again.
- R3: Edge 1 is the first edge with `rst` low. After a reset, the settle timer raises `load_end` after edges 2^(SU_W-1)+3 and 2^(SU_W-1)+4 (edges 35 and 36 for SU_W=6). `load_end` is low after every other edge, provided that no stop request arrives and the program counter is not above the terminal address.
- R4: The settle counter stops once its two top bits read binary 10. No second settle pulse follows, however long the block runs.
- R5: A stop request produces `load_end` with the same timing as the start path in R1: high after edges 3 and 4, counted from the first edge that samples `stop_req` high.
- R6: Call A the first edge that samples `pc` > `end_mark` (unsigned). A single-cycle violation gives `load_end` high after edges A+1 and A+2. While the violation persists, the internal over-flag alternates between 1 and 0, and `load_end` stays high continuously.
- R7: At each edge, `run_state` takes STOP_CODE (default 0) if `pc` equals `end_mark` and RUN_CODE (default 1) otherwise.
- R8: While `rst` is high at an edge, `load_begin`, `load_end` and `begin_first` read 0 and `run_state` reads STOP_CODE.
- R9: Stop requests never move `load_begin` or `begin_first`. Start requests never move `load_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Asynchronous run request |
| stop_req | input | 1 | Asynchronous halt request |
| pc | input | PC_W | Current program counter of the sequencer |
| end_mark | input | PC_W | Terminal program address (constant in use) |
| load_begin | output | 1 | Two-clock load-first-address pulse |
| load_end | output | 1 | Two-clock load-terminal-address pulse |
| begin_first | output | 1 | Registered start edge, high in the first load_begin cycle |
| run_state | output | 1 | RUN_CODE while running, STOP_CODE when parked |

## Verification
The assertions check the following on every cycle:
- each rising-edge event lasts one clock;
- each trigger is followed by a stretched output;
- no stretched output appears without a trigger;
- the settle counter advances only while its flag is set and freezes at its terminal pattern;
- the over-flag never stays high two cycles in a row;
- the status register follows the address comparison.

Only the bench scenarios can show the absolute latencies: three edges from a request to its pulse, and 35 edges from reset to the settle pulse. The same holds for the continuous `load_end` under a persistent violation, for the single response to a held request, and for the isolation of the start and stop paths from each other.

// File: rtl/run_ctl_pkg.sv
package run_ctl_pkg;

  // Events that can request a load of the terminal address
  typedef struct packed {
    logic halt_edge;
    logic settle_done;
    logic pc_over;
  } end_cause_t;

  function automatic logic any_cause(input end_cause_t c);
    return c.halt_edge | c.settle_done | c.pc_over;
  endfunction

endpackage

// File: rtl/rc_req_sync.sv
module rc_req_sync #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic rise
);
  localparam int LAST = DEPTH - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST-1:0], req_async};
  end

  // edge seen between the two oldest stages
  assign rise = chain[LAST-1] & ~chain[LAST];

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/rc_stretch2.sv
module rc_stretch2 (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic first_q,
  output logic wide_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      first_q <= trig;
      wide_q  <= trig | first_q;
    end
  end

  // R1
  trig_to_wide_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (wide_q && first_q));
  // R5
  second_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    first_q |=> wide_q);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig && !first_q) |=> !wide_q);

endmodule

// File: rtl/rc_settle.sv
module rc_settle #(
  parameter int SU_W = 6
) (
  input  logic clk,
  input  logic rst,
  output logic done_pulse
);
  localparam int TOP = SU_W - 1;

  logic [TOP:0] cnt;
  logic         busy;
  logic         busy_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      busy    <= 1'b0;
      busy_d1 <= 1'b0;
    end else begin
      if (busy) cnt <= cnt + 1'b1;
      busy    <= (cnt[TOP:TOP-1] != 2'b10);
      busy_d1 <= busy;
    end
  end

  assign done_pulse = busy_d1 & ~busy;

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> cnt == SU_W'($past(cnt) + 1'b1));
  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnt[TOP:TOP-1] == 2'b10) |=> (!busy && $stable(cnt)));

endmodule

// File: rtl/rc_pc_watch.sv
module rc_pc_watch #(
  parameter int   PC_W      = 8,
  parameter logic RUN_CODE  = 1'b1,
  parameter logic STOP_CODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] end_mark,
  output logic            over_q,
  output logic            state_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      over_q  <= 1'b0;
      state_q <= STOP_CODE;
    end else begin
      over_q  <= (pc > end_mark) & ~over_q;
      state_q <= (pc == end_mark) ? STOP_CODE : RUN_CODE;
    end
  end

  // R6
  over_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    over_q |=> !over_q);
  // R6
  over_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((pc > end_mark) && !over_q) |=> over_q);
  // R7
  parked_chk: assert property (@(posedge clk) disable iff (rst)
    (pc == end_mark) |=> state_q == STOP_CODE);

endmodule

// File: rtl/run_ctl.sv
module run_ctl
  import run_ctl_pkg::*;
#(
  parameter int   PC_W      = 8,
  parameter int   SYNC_D    = 3,
  parameter int   SU_W      = 6,
  parameter logic RUN_CODE  = 1'b1,
  parameter logic STOP_CODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] end_mark,
  output logic            load_begin,
  output logic            load_end,
  output logic            begin_first,
  output logic            run_state
);
  logic       go_rise;
  logic       halt_rise;
  logic       settle_done;
  logic       over_q;
  logic       end_first;
  end_cause_t cause;

  rc_req_sync #(.DEPTH(SYNC_D)) u_go_sync (
    .clk(clk), .rst(rst), .req_async(start_req), .rise(go_rise));

  rc_req_sync #(.DEPTH(SYNC_D)) u_halt_sync (
    .clk(clk), .rst(rst), .req_async(stop_req), .rise(halt_rise));

  rc_settle #(.SU_W(SU_W)) u_settle (
    .clk(clk), .rst(rst), .done_pulse(settle_done));

  rc_pc_watch #(.PC_W(PC_W), .RUN_CODE(RUN_CODE), .STOP_CODE(STOP_CODE)) u_watch (
    .clk(clk), .rst(rst), .pc(pc), .end_mark(end_mark),
    .over_q(over_q), .state_q(run_state));

  always_comb begin
    cause.halt_edge   = halt_rise;
    cause.settle_done = settle_done;
    cause.pc_over     = over_q;
  end

  rc_stretch2 u_begin_str (
    .clk(clk), .rst(rst), .trig(go_rise),
    .first_q(begin_first), .wide_q(load_begin));

  rc_stretch2 u_end_str (
    .clk(clk), .rst(rst), .trig(any_cause(cause)),
    .first_q(end_first), .wide_q(load_end));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!load_begin && !load_end && !begin_first));
  // R1
  first_inside_chk: assert property (@(posedge clk) disable iff (rst)
    begin_first |-> load_begin);

endmodule

// File: tb/sim_run_ctl.sv
module sim_run_ctl;
  localparam int PC_W = 8;
  localparam int SU_W = 6;
  localparam int SETTLE_EDGE = (1 << (SU_W - 1)) + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic stop_req = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic [PC_W-1:0] end_mark = 8'd5;
  logic load_begin, load_end, begin_first, run_state;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  run_ctl #(.PC_W(PC_W), .SU_W(SU_W)) u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .pc(pc), .end_mark(end_mark), .load_begin(load_begin),
    .load_end(load_end), .begin_first(begin_first), .run_state(run_state));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) step();
    check("R8 load_begin", load_begin, 1'b0);
    check("R8 load_end", load_end, 1'b0);
    check("R8 begin_first", begin_first, 1'b0);
    check("R8 run_state", run_state, 1'b0);

    // R3 settle pulse timing, R7 running status
    rst = 1'b0;
    for (int k = 1; k <= SETTLE_EDGE + 10; k++) begin
      step();
      check("R3 settle load_end", load_end, (k == SETTLE_EDGE || k == SETTLE_EDGE + 1));
      check("R7 running", run_state, 1'b1);
    end
    // R4 no further settle pulse
    for (int k = 0; k < 200; k++) begin
      step();
      check("R4 quiet", load_end, 1'b0);
    end

    // R1/R9 start path, request widths 1..6
    for (int w = 1; w <= 6; w++) begin
      start_req = 1'b1;
      for (int k = 1; k <= w + 8; k++) begin
        step();
        if (k == w) start_req = 1'b0;
        check("R1 load_begin", load_begin, (k == 3 || k == 4));
        check("R1 begin_first", begin_first, (k == 3));
        check("R9 load_end idle", load_end, 1'b0);
      end
    end

    // R2 held start gives one pair
    start_req = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      step();
      check("R2 held start", load_begin, (k == 3 || k == 4));
    end
    start_req = 1'b0;
    repeat (6) step();

    // R5/R9 stop path
    for (int w = 1; w <= 6; w++) begin
      stop_req = 1'b1;
      for (int k = 1; k <= w + 8; k++) begin
        step();
        if (k == w) stop_req = 1'b0;
        check("R5 load_end", load_end, (k == 3 || k == 4));
        check("R9 load_begin idle", load_begin, 1'b0);
        check("R9 begin_first idle", begin_first, 1'b0);
      end
    end

    // R7 status sweep of pc up to end_mark
    for (int p = 0; p <= 5; p++) begin
      pc = PC_W'(p);
      step();
      check("R7 status", run_state, (p != 5));
      check("R7 no load_end", load_end, 1'b0);
    end
    pc = '0;
    step();

    // R6 one-cycle violation
    pc = 8'd6;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (k == 1) pc = '0;
      check("R6 single", load_end, (k == 2 || k == 3));
    end

    // R6 persistent violation for 10 edges
    begin
      logic g1, g2, gn;
      g1 = 1'b0;
      g2 = 1'b0;
      pc = 8'd7;
      for (int k = 1; k <= 14; k++) begin
        step();
        gn = (k <= 10) && !g1;
        check("R6 persistent", load_end, g1 | g2);
        g2 = g1;
        g1 = gn;
        if (k == 10) pc = '0;
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule